// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Output

This block recovers asynchronous serial characters from a line that it samples thirteen times per bit period, paced by an oversample tick that arrives as a one-cycle enable. It handles 7- or 8-bit characters, with an optional even or odd parity bit and one stop bit. Every character is handed over as a 10-bit word: the data sits in the low byte, a parity-mismatch flag sits just above it, and a stop-bit flag sits at the top. The consumer does not have to re-derive which character was bad.

A receive-enable, a data-length select, a parity enable, a parity sense and a loopback select come straight from line-control fields held elsewhere. In loopback the receiver listens to the local transmit line and ignores the external pin. After taking a character, the consumer pulses an acknowledge. Two status flags come from that handshake. One is an overrun, raised when a new character lands on one that was never taken. The other is a receive timeout, raised when a taken-but-unread character has been followed by a long silence.

The receiver is a five-state machine. IDLE waits for a low line on a tick, and goes to START. START checks the line at the middle tick: a high line there returns to IDLE as a false start, and otherwise the machine moves to DATA at the end of the bit. DATA samples each bit at its middle tick. After the last bit it goes to PARITY when parity is enabled, and to STOP when it is not. PARITY samples the parity bit and then goes to STOP. STOP samples the stop bit at its middle tick, delivers the word and returns to IDLE at once. Dropping the receive enable sends every state back to IDLE.

Top module: `serial_rx_top`

## Requirements
- R1: A low level seen on a tick starts a frame. That tick is tick 0. If the line is high again at tick 6 (the 7th of 13), the frame is abandoned, nothing is delivered, and the receiver waits for a new start.
- R2: Data bits arrive least significant first. Each is sampled at tick 6 of its 13-tick period. With `len8_i`=1, eight bits land in `char_word_o[7:0]`.
- R3: With `len8_i`=0, seven bits are received into `char_word_o[6:0]` and `char_word_o[7]` is 0.
- R4: With `par_en_i`=1, one parity bit follows the data. `char_word_o[8]` is 1 when the ones count over data and parity bit is odd while `par_odd_i`=0 (even sense), or even while `par_odd_i`=1 (odd sense). With `par_en_i`=0, bit 8 is 0.
- R5: `char_word_o[9]` is 1 when the stop bit is low at its middle tick, and 0 when it is high.
- R6: `char_vld_o` is high for exactly one cycle per received character, and `char_word_o` is valid in that cycle.
- R7: With `loop_en_i`=1 the receiver takes its input from `tx_loop_i` and ignores `rx_pin_i`. With `loop_en_i`=0 the reverse holds.
- R8: With `rx_en_i`=0 no character is delivered, whatever the line does.
- R9: `overrun_o` is set when a character is delivered while the previous one has not been acknowledged. A pulse on `rd_ack_i` clears it.
- R10: `rx_timeout_o` is set when a delivered character stays unacknowledged and no start bit arrives for four character times. A character time is 13 ticks times the frame bit count (start + data + parity + stop). An acknowledge or a new start clears it.
- R11: After reset, `char_vld_o`, `char_word_o`, `overrun_o` and `rx_timeout_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_pin_i | input | 1 | External serial input, idle high |
| tx_loop_i | input | 1 | Local transmit line used in loopback |
| os_tick_i | input | 1 | Oversample enable, 13 per bit period |
| rx_en_i | input | 1 | Receive enable |
| len8_i | input | 1 | 1: eight data bits, 0: seven |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| loop_en_i | input | 1 | Select the local transmit line as input |
| rd_ack_i | input | 1 | Consumer has taken the delivered word |
| char_vld_o | output | 1 | One-cycle strobe for a new word |
| char_word_o | output | 10 | {frame error, parity error, data[7:0]} |
| overrun_o | output | 1 | Character lost over an unread one |
| rx_timeout_o | output | 1 | Unread data with a quiet line |

## Verification
The bench sends a short low glitch. A receiver that trusted the falling edge alone would hand out a spurious 0x00 or 0xFF character. Both parity senses are checked with correct and corrupted parity bits, and a bad stop bit is sent on its own and together with bad parity, so an inverted sense or a swapped flag position shows up as a wrong word. Seven-bit frames are sent with a set eighth bit in the source byte, which catches a receiver that samples one bit too many. The timeout is probed shortly before and shortly after the four-character window to catch an off-by-scale limit. Loopback, disable and overrun are checked by watching whether a character appears on the port, and which one.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic              frame_err;
        logic              par_err;
        logic [DATA_W-1:0] data;
    } rx_word_t;

endpackage

// File: rtl/serial_rx_fsm.sv
module serial_rx_fsm
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 13,
    parameter int MID         = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     line_i,
    input  logic     tick_i,
    input  logic     en_i,
    input  logic     len8_i,
    input  logic     par_en_i,
    input  logic     par_odd_i,
    output logic     busy_o,
    output logic     done_o,
    output rx_word_t word_o
);

    localparam int TW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    rx_state_e state_q, state_d;
    logic [SYNC_STAGES-1:0] sync_q;
    logic [TW-1:0]          tcnt_q;
    logic [BW-1:0]          bitcnt_q;
    logic [DATA_W-1:0]      data_q;
    logic                   perr_q;
    logic                   line_s;
    logic                   at_mid, at_end;
    logic [BW-1:0]          last_bit;

    // input synchronizer, idle level high
    generate
        if (SYNC_STAGES == 1) begin : g_sync1
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= line_i;
            end
        end else begin : g_syncn
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            end
        end
    endgenerate

    assign line_s   = sync_q[SYNC_STAGES-1];
    assign at_mid   = tick_i && (tcnt_q == TW'(MID));
    assign at_end   = tick_i && (tcnt_q == TW'(OSR-1));
    assign last_bit = len8_i ? BW'(DATA_W-1) : BW'(DATA_W-2);
    assign busy_o   = (state_q != RX_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:   if (tick_i && !line_s) state_d = RX_START;
            RX_START:  if (at_mid && line_s) state_d = RX_IDLE;
                       else if (at_end)      state_d = RX_DATA;
            RX_DATA:   if (at_end && bitcnt_q == last_bit)
                           state_d = par_en_i ? RX_PARITY : RX_STOP;
            RX_PARITY: if (at_end) state_d = RX_STOP;
            RX_STOP:   if (at_mid) state_d = RX_IDLE;
            default:   state_d = RX_IDLE;
        endcase
        if (!en_i) state_d = RX_IDLE;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tcnt_q   <= '0;
            bitcnt_q <= '0;
            data_q   <= '0;
            perr_q   <= 1'b0;
            done_o   <= 1'b0;
            word_o   <= '0;
        end else begin
            done_o <= 1'b0;
            if (!en_i || state_q == RX_IDLE) begin
                tcnt_q   <= TW'(1);   // detection tick counts as tick 0
                bitcnt_q <= '0;
                data_q   <= '0;
                perr_q   <= 1'b0;
            end else if (tick_i) begin
                tcnt_q <= at_end ? '0 : tcnt_q + TW'(1);
                unique case (state_q)
                    RX_DATA: begin
                        if (at_mid) data_q[bitcnt_q] <= line_s;
                        if (at_end) bitcnt_q <= bitcnt_q + BW'(1);
                    end
                    RX_PARITY: begin
                        if (at_mid) perr_q <= ((^data_q) ^ line_s) != par_odd_i;
                    end
                    RX_STOP: begin
                        if (at_mid) begin
                            done_o <= 1'b1;
                            word_o <= '{frame_err: ~line_s,
                                        par_err:   par_en_i & perr_q,
                                        data:      data_q};
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status #(
    parameter int OSR      = 13,
    parameter int TO_CHARS = 4,
    parameter int CNT_W    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic busy_i,
    input  logic done_i,
    input  logic ack_i,
    input  logic len8_i,
    input  logic par_en_i,
    output logic ovr_o,
    output logic tmo_o
);

    logic             pend_q;
    logic [CNT_W-1:0] cnt_q;
    logic [3:0]       frame_bits;
    logic [CNT_W-1:0] limit;

    // start + 7 data + stop = 9, plus options
    assign frame_bits = 4'd9 + {3'd0, len8_i} + {3'd0, par_en_i};
    assign limit      = CNT_W'(TO_CHARS * OSR) * CNT_W'(frame_bits);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ovr_o  <= 1'b0;
        end else begin
            if (done_i)     pend_q <= 1'b1;
            else if (ack_i) pend_q <= 1'b0;
            if (ack_i)                ovr_o <= 1'b0;
            else if (done_i && pend_q) ovr_o <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmo_o <= 1'b0;
        end else if (ack_i || busy_i || done_i) begin
            cnt_q <= '0;
            tmo_o <= 1'b0;
        end else if (pend_q && tick_i && !tmo_o) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (cnt_q + CNT_W'(1) == limit) tmo_o <= 1'b1;
        end
    end

endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
    import serial_rx_pkg::*;
#(
    parameter int OSR         = 13,
    parameter int MID         = 6,
    parameter int SYNC_STAGES = 2,
    parameter int TO_CHARS    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_pin_i,
    input  logic       tx_loop_i,
    input  logic       os_tick_i,
    input  logic       rx_en_i,
    input  logic       len8_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       loop_en_i,
    input  logic       rd_ack_i,
    output logic       char_vld_o,
    output logic [9:0] char_word_o,
    output logic       overrun_o,
    output logic       rx_timeout_o
);

    localparam int MAX_FRAME = DATA_W + 3;
    localparam int TO_W      = $clog2(TO_CHARS * OSR * MAX_FRAME + 1);

    logic     line_sel;
    logic     busy;
    rx_word_t word;

    assign line_sel = loop_en_i ? tx_loop_i : rx_pin_i;

    serial_rx_fsm #(
        .OSR(OSR), .MID(MID), .SYNC_STAGES(SYNC_STAGES)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .line_i(line_sel), .tick_i(os_tick_i),
        .en_i(rx_en_i), .len8_i(len8_i), .par_en_i(par_en_i),
        .par_odd_i(par_odd_i), .busy_o(busy), .done_o(char_vld_o),
        .word_o(word)
    );

    serial_rx_status #(
        .OSR(OSR), .TO_CHARS(TO_CHARS), .CNT_W(TO_W)
    ) stat_i (
        .clk(clk), .rst_n(rst_n), .tick_i(os_tick_i), .busy_i(busy),
        .done_i(char_vld_o), .ack_i(rd_ack_i), .len8_i(len8_i),
        .par_en_i(par_en_i), .ovr_o(overrun_o), .tmo_o(rx_timeout_o)
    );

    assign char_word_o = word;

endmodule

// File: rtl/serial_rx_chk.sv
module serial_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en_i,
    input logic       len8_i,
    input logic       par_en_i,
    input logic       rd_ack_i,
    input logic       char_vld_o,
    input logic [9:0] char_word_o,
    input logic       overrun_o,
    input logic       rx_timeout_o
);

    // R6
    vld_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        char_vld_o |=> !char_vld_o);

    // R8
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en_i |=> !char_vld_o);

    // R3
    short_char_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld_o && !len8_i) |-> !char_word_o[7]);

    // R4
    no_parity_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (char_vld_o && !par_en_i) |-> !char_word_o[8]);

    // R9
    overrun_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i |=> !overrun_o);

    // R9
    overrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(char_vld_o));

    // R10
    timeout_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack_i |=> !rx_timeout_o);

endmodule

bind serial_rx_top serial_rx_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en_i), .len8_i(len8_i),
    .par_en_i(par_en_i), .rd_ack_i(rd_ack_i), .char_vld_o(char_vld_o),
    .char_word_o(char_word_o), .overrun_o(overrun_o),
    .rx_timeout_o(rx_timeout_o)
);

// File: tb/serial_rx_top_tb_top.sv
`timescale 1ns/1ps
module serial_rx_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_pin = 1'b1, tx_loop = 1'b1, os_tick = 1'b0;
    logic       rx_en = 1'b1, len8 = 1'b1, par_en = 1'b0, par_odd = 1'b0;
    logic       loop_en = 1'b0, rd_ack = 1'b0;
    logic       char_vld, overrun, rx_timeout;
    logic [9:0] char_word;

    int         n_checks = 0, n_errors = 0, got = 0;
    logic [9:0] last_word = '0;

    always #2 clk = ~clk;   // 250 MHz

    serial_rx_top dut_i (
        .clk(clk), .rst_n(rst_n), .rx_pin_i(rx_pin), .tx_loop_i(tx_loop),
        .os_tick_i(os_tick), .rx_en_i(rx_en), .len8_i(len8),
        .par_en_i(par_en), .par_odd_i(par_odd), .loop_en_i(loop_en),
        .rd_ack_i(rd_ack), .char_vld_o(char_vld), .char_word_o(char_word),
        .overrun_o(overrun), .rx_timeout_o(rx_timeout)
    );

    // oversample tick every second cycle
    always @(negedge clk) os_tick <= ~os_tick;

    always @(negedge clk) if (char_vld) begin
        got++;
        last_word <= char_word;
    end

    // {len8, par_en, par_odd, bad_stop, bad_par, data[7:0], expected[9:0]}
    localparam logic [22:0] VEC [8] = '{
        {1'b1,1'b0,1'b0,1'b0,1'b0, 8'hA5, 10'h0A5},   // R2
        {1'b1,1'b1,1'b0,1'b0,1'b0, 8'h3C, 10'h03C},   // R4 even ok
        {1'b1,1'b1,1'b1,1'b0,1'b0, 8'h3C, 10'h03C},   // R4 odd ok
        {1'b1,1'b1,1'b0,1'b0,1'b1, 8'h81, 10'h181},   // R4 even bad
        {1'b0,1'b0,1'b0,1'b0,1'b0, 8'hD5, 10'h055},   // R3
        {1'b1,1'b0,1'b0,1'b1,1'b0, 8'h0F, 10'h20F},   // R5
        {1'b0,1'b1,1'b1,1'b0,1'b0, 8'h13, 10'h013},   // R3 R4 odd ok
        {1'b1,1'b1,1'b1,1'b1,1'b1, 8'h00, 10'h300}    // R4 R5
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input bit on_loop);
        if (on_loop) tx_loop = v; else rx_pin = v;
    endtask

    task automatic hold_ticks(input int n);
        repeat (2 * n) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit l8, input bit pe, input bit po,
                        input bit bad_stop, input bit bad_par, input bit on_loop);
        int  nb = l8 ? 8 : 7;
        logic p = 1'b0;
        drive(1'b0, on_loop); hold_ticks(13);
        for (int i = 0; i < nb; i++) begin
            p ^= d[i];
            drive(d[i], on_loop); hold_ticks(13);
        end
        if (pe) begin
            drive(p ^ po ^ bad_par, on_loop); hold_ticks(13);
        end
        drive(~bad_stop, on_loop); hold_ticks(13);
        drive(1'b1, on_loop); hold_ticks(3);
    endtask

    task automatic ack();
        @(negedge clk) rd_ack = 1'b1;
        @(negedge clk) rd_ack = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #600000;
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int g0;
        repeat (10) @(negedge clk);
        // R11 reset state
        check("R11 vld", char_vld, 0);
        check("R11 word", char_word, 0);
        check("R11 ovr", overrun, 0);
        check("R11 tmo", rx_timeout, 0);
        rst_n = 1'b1;
        hold_ticks(4);

        foreach (VEC[k]) begin
            len8 = VEC[k][22]; par_en = VEC[k][21]; par_odd = VEC[k][20];
            g0 = got;
            send(VEC[k][17:10], VEC[k][22], VEC[k][21], VEC[k][20],
                 VEC[k][19], VEC[k][18], 1'b0);
            check("R6 one strobe per char", got - g0, 1);
            check("R2/R3/R4/R5 tagged word", last_word, VEC[k][9:0]);
            check("R9 no overrun when read", overrun, 0);
            ack();
        end
        len8 = 1'b1; par_en = 1'b0; par_odd = 1'b0;

        // R9 overrun
        send(8'h11, 1, 0, 0, 0, 0, 0);
        send(8'h22, 1, 0, 0, 0, 0, 0);
        check("R9 overrun set", overrun, 1);
        check("R9 newest word", last_word, 10'h022);
        ack();
        @(negedge clk);
        check("R9 overrun cleared", overrun, 0);

        // R10 timeout: 4 chars * 130 ticks = 1040 cycles after delivery
        send(8'h33, 1, 0, 0, 0, 0, 0);
        repeat (960) @(negedge clk);
        check("R10 not yet", rx_timeout, 0);
        repeat (120) @(negedge clk);
        check("R10 timeout set", rx_timeout, 1);
        ack();
        @(negedge clk);
        check("R10 timeout cleared", rx_timeout, 0);

        // R1 false start: low for 4 ticks only
        g0 = got;
        rx_pin = 1'b0; hold_ticks(4);
        rx_pin = 1'b1; hold_ticks(30);
        check("R1 glitch ignored", got - g0, 0);
        send(8'hC3, 1, 0, 0, 0, 0, 0);
        check("R1 next frame ok", last_word, 10'h0C3);
        ack();

        // R8 receive disabled
        rx_en = 1'b0;
        g0 = got;
        send(8'h5A, 1, 0, 0, 0, 0, 0);
        check("R8 disabled ignores line", got - g0, 0);
        rx_en = 1'b1;
        hold_ticks(4);

        // R7 loopback
        loop_en = 1'b1;
        g0 = got;
        send(8'h5A, 1, 0, 0, 0, 0, 1);
        check("R7 loop char seen", got - g0, 1);
        check("R7 loop word", last_word, 10'h05A);
        ack();
        g0 = got;
        send(8'h00, 1, 0, 0, 0, 0, 0);
        check("R7 pin ignored in loopback", got - g0, 0);
        loop_en = 1'b0;
        hold_ticks(4);
        g0 = got;
        send(8'h00, 1, 0, 0, 0, 0, 1);
        check("R7 loop line ignored normally", got - g0, 0);

        finish_run();
    end

endmodule